// File: doc/BRIEF.md
# Fixed-Point Scaled System Time Counter

This block keeps the free-running system time of a network interface. On every tick of the timing oscillator, it adds a programmable fixed-point increment to a 64-bit accumulator. The accumulator holds scaled time units. Its lowest `FRAC_W` bits are a binary fraction of a nanosecond, so a right shift by `FRAC_W` turns it into nanoseconds with no multiplier. The reset increment is one nominal oscillator period of 6.4 ns in these units.

The oscillator period grows by 10x and by 100x at the two lower link speeds. The block scales the programmed increment by the matching factor from the `link_speed` input, so one programmed value serves every speed. Software can load a new increment through its register port. Frequency-trim logic can also replace the increment. A set-time load overwrites the whole accumulator at once.

Software reads the time as two 32-bit words through a request/response port. A low-word read also freezes the high word in a shadow, so a following high-word read belongs to the same instant. The response is returned exactly one cycle after the request and cannot be stalled. There is no ready signal, and the requester must accept `rd_data` while `rd_vld` is high.

Top module: `scaled_systime`

## Requirements
- R1: After reset the accumulator is zero and the increment register holds 13421772 (6.4 ns with 21 fraction bits). A low-word read and a high-word read both return 0.
- R2: In a cycle with `osc_tick` high and no set-time load, the accumulator advances by the scaled increment at that clock edge. With `osc_tick` low and no set-time load, it holds.
- R3: The scaled increment is the increment register multiplied by a factor taken from `link_speed`. Code 0 (fast) gives x1, code 1 (middle) gives x10, code 2 (slow) gives x100, and code 3 (no link) gives x1.
- R4: `inc_wr` loads `inc_wdata` into the increment register without changing the accumulator. A tick in the same cycle as the write still uses the old increment. The new value applies from the next tick.
- R5: `trim_ld` loads `trim_val` into the increment register. When `trim_ld` and `inc_wr` are high in the same cycle, the trim value wins.
- R6: `set_ld` overwrites the accumulator with {`set_hi`,`set_lo`} in one cycle. This takes priority over a tick in the same cycle.
- R7: A read request (`rd_en`) gives `rd_vld` high with `rd_data` in the next cycle. `rd_sel`=0 returns accumulator bits 31:0 and captures bits 63:32 into the shadow. `rd_sel`=1 returns the shadow, unaffected by ticks since the last low-word read.
- R8: `time_ns` equals the accumulator shifted right by 21 (`FRAC_W`) bits.
- R9: The accumulator wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator tick strobe |
| link_speed | input | 2 | 0 fast, 1 middle, 2 slow, 3 no link |
| inc_wr | input | 1 | Increment register write strobe |
| inc_wdata | input | 24 | Increment write value |
| trim_ld | input | 1 | Frequency-trim increment load |
| trim_val | input | 24 | Trimmed increment value |
| set_ld | input | 1 | Set-time load strobe |
| set_hi | input | 32 | New time, high word |
| set_lo | input | 32 | New time, low word |
| rd_en | input | 1 | Read request |
| rd_sel | input | 1 | 0 low word, 1 high word (shadow) |
| rd_data | output | 32 | Read response data |
| rd_vld | output | 1 | Read response valid |
| time_ns | output | 43 | Accumulator in whole nanoseconds |

## Verification
The bench places a low-word read just before a tick that carries into the high word. It then reads the high word and expects the pre-carry value; a design without the shadow would return a torn time. It applies a set-time load and a tick in the same cycle, and applies an increment write and a tick in the same cycle. A wrong priority in either case shows up as an offset of exactly one increment. Each speed code is checked against its factor, and code 3 is expected to fall back to x1 rather than x100. The bench also drives a trim load together with a software write, and a tick across the 64-bit wrap point.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [1:0] {
    SPD_FAST = 2'd0,
    SPD_MID  = 2'd1,
    SPD_SLOW = 2'd2,
    SPD_NONE = 2'd3
  } speed_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/stc_inc_reg.sv
module stc_inc_reg #(
  parameter int unsigned INC_W = 24,
  parameter logic [INC_W-1:0] INC_DEF = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [INC_W-1:0] wdata,
  input  logic             trim_ld,
  input  logic [INC_W-1:0] trim_val,
  output logic [INC_W-1:0] inc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       inc_q <= INC_DEF;
    else if (trim_ld) inc_q <= trim_val;
    else if (wr)      inc_q <= wdata;
  end
endmodule

// File: rtl/stc_scaler.sv
module stc_scaler
  import stc_pkg::*;
#(
  parameter int unsigned INC_W = 24,
  parameter int unsigned SC_W  = INC_W + 7
) (
  input  logic [INC_W-1:0] inc,
  input  logic [1:0]       speed,
  output logic [SC_W-1:0]  scaled
);
  logic [SC_W-1:0] base;
  logic [SC_W-1:0] x10;
  logic [SC_W-1:0] x100;

  assign base = SC_W'(inc);
  assign x10  = (base << 3) + (base << 1);
  assign x100 = (base << 6) + (base << 5) + (base << 2);

  always_comb begin
    unique case (speed_e'(speed))
      SPD_MID:  scaled = x10;
      SPD_SLOW: scaled = x100;
      default:  scaled = base;
    endcase
  end
endmodule

// File: rtl/stc_accum.sv
module stc_accum #(
  parameter int unsigned ACC_W = 64,
  parameter int unsigned SC_W  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SC_W-1:0]  step,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= load_val;
    else if (tick) acc_q <= acc_q + ACC_W'(step);
  end
endmodule

// File: rtl/stc_rd_port.sv
module stc_rd_port #(
  parameter int unsigned WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                rd_sel,
  input  logic [2*WORD_W-1:0] acc,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_vld
);
  logic [WORD_W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      rd_data  <= '0;
      rd_vld   <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) begin
        if (rd_sel) begin
          rd_data <= shadow_q;
        end else begin
          rd_data  <= acc[WORD_W-1:0];
          shadow_q <= acc[2*WORD_W-1:WORD_W];
        end
      end
    end
  end
endmodule

// File: rtl/scaled_systime.sv
module scaled_systime
  import stc_pkg::*;
#(
  parameter int unsigned INC_W     = 24,
  parameter int unsigned FRAC_W    = 21,
  parameter int unsigned PERIOD_PS = 6400
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         osc_tick,
  input  logic [1:0]                   link_speed,
  input  logic                         inc_wr,
  input  logic [INC_W-1:0]             inc_wdata,
  input  logic                         trim_ld,
  input  logic [INC_W-1:0]             trim_val,
  input  logic                         set_ld,
  input  logic [WORD_W-1:0]            set_hi,
  input  logic [WORD_W-1:0]            set_lo,
  input  logic                         rd_en,
  input  logic                         rd_sel,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_vld,
  output logic [2*WORD_W-FRAC_W-1:0]   time_ns
);
  localparam int unsigned ACC_W = 2 * WORD_W;
  localparam int unsigned SC_W  = INC_W + 7;
  localparam longint unsigned DEF_FULL =
    (longint'(PERIOD_PS) * (64'd1 << FRAC_W)) / 64'd1000;
  localparam logic [INC_W-1:0] INC_DEF = INC_W'(DEF_FULL);

  logic [INC_W-1:0] inc_q;
  logic [SC_W-1:0]  scaled;
  logic [ACC_W-1:0] acc_q;

  stc_inc_reg #(.INC_W(INC_W), .INC_DEF(INC_DEF)) u_inc (
    .clk(clk), .rst_n(rst_n), .wr(inc_wr), .wdata(inc_wdata),
    .trim_ld(trim_ld), .trim_val(trim_val), .inc_q(inc_q)
  );

  stc_scaler #(.INC_W(INC_W), .SC_W(SC_W)) u_scale (
    .inc(inc_q), .speed(link_speed), .scaled(scaled)
  );

  stc_accum #(.ACC_W(ACC_W), .SC_W(SC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .step(scaled),
    .load(set_ld), .load_val({set_hi, set_lo}), .acc_q(acc_q)
  );

  stc_rd_port #(.WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel),
    .acc(acc_q), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  assign time_ns = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/scaled_systime_chk.sv
module scaled_systime_chk #(
  parameter int unsigned INC_W = 24,
  parameter int unsigned SC_W  = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             set_ld,
  input logic [31:0]      set_hi,
  input logic [31:0]      set_lo,
  input logic             trim_ld,
  input logic [INC_W-1:0] trim_val,
  input logic             rd_en,
  input logic             rd_sel,
  input logic [31:0]      rd_data,
  input logic             rd_vld,
  input logic [INC_W-1:0] inc_q,
  input logic [SC_W-1:0]  scaled,
  input logic [63:0]      acc_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !set_ld) |=> $stable(acc_q));

  p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !set_ld) |=> acc_q == $past(acc_q) + 64'($past(scaled)));

  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_ld |=> acc_q == {$past(set_hi), $past(set_lo)});

  p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trim_ld |=> inc_q == $past(trim_val));

  p_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);

  p_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sel) |=> rd_data == $past(acc_q[31:0]));
endmodule

bind scaled_systime scaled_systime_chk #(.INC_W(INC_W), .SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .set_ld(set_ld),
  .set_hi(set_hi), .set_lo(set_lo), .trim_ld(trim_ld), .trim_val(trim_val),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_vld(rd_vld),
  .inc_q(inc_q), .scaled(scaled), .acc_q(acc_q)
);

// File: tb/scaled_systime_test.sv
module scaled_systime_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic        inc_wr = 1'b0;
  logic [23:0] inc_wdata = '0;
  logic        trim_ld = 1'b0;
  logic [23:0] trim_val = '0;
  logic        set_ld = 1'b0;
  logic [31:0] set_hi = '0;
  logic [31:0] set_lo = '0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_vld;
  logic [42:0] time_ns;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_t;

  scaled_systime uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .link_speed(link_speed),
    .inc_wr(inc_wr), .inc_wdata(inc_wdata), .trim_ld(trim_ld),
    .trim_val(trim_val), .set_ld(set_ld), .set_hi(set_hi), .set_lo(set_lo),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_vld(rd_vld),
    .time_ns(time_ns)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    rd_en = 1'b1; rd_sel = sel;
    step();
    rd_en = 1'b0;
    chk("R7 rd_vld", 64'(rd_vld), 64'd1);
    d = rd_data;
  endtask

  task automatic read_time(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1;
      step();
    end
    osc_tick = 1'b0;
  endtask

  task automatic set_time(input logic [63:0] v);
    set_ld = 1'b1; set_hi = v[63:32]; set_lo = v[31:0];
    step();
    set_ld = 1'b0;
  endtask

  task automatic write_inc(input logic [23:0] v);
    inc_wr = 1'b1; inc_wdata = v;
    step();
    inc_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_vld idle", 64'(rd_vld), 64'd0);
    chk("R8 time_ns at reset", 64'(time_ns), 64'd0);
    read_time("R1 time zero", 64'd0);
    tick(1);
    read_time("R1 default increment", 64'd13421772);
    chk("R8 time_ns 6", 64'(time_ns), 64'd6);
  endtask

  task automatic t_set();
    exp_t = 64'h0000_0012_3456_789A;
    set_time(exp_t);
    read_time("R6 set value", exp_t);
    chk("R8 time_ns shift", 64'(time_ns), exp_t >> 21);
    osc_tick = 1'b1; set_ld = 1'b1; set_hi = 32'h1; set_lo = 32'h40;
    step();
    osc_tick = 1'b0; set_ld = 1'b0;
    read_time("R6 set beats tick", 64'h1_0000_0040);
  endtask

  task automatic t_inc_write();
    set_time(64'd5000);
    write_inc(24'd1000);
    read_time("R4 write leaves time", 64'd5000);
    tick(3);
    read_time("R4 new increment x3", 64'd8000);
    inc_wr = 1'b1; inc_wdata = 24'd50; osc_tick = 1'b1;
    step();
    inc_wr = 1'b0; osc_tick = 1'b0;
    read_time("R4 same-cycle old inc", 64'd9000);
    tick(1);
    read_time("R4 next tick new inc", 64'd9050);
    chk("R2 hold without tick", 64'(time_ns), 64'd0);
    read_time("R2 hold value", 64'd9050);
  endtask

  task automatic t_speed();
    write_inc(24'd1000);
    set_time(64'd0);
    link_speed = 2'd1; tick(1);
    read_time("R3 middle x10", 64'd10000);
    link_speed = 2'd2; tick(1);
    read_time("R3 slow x100", 64'd110000);
    link_speed = 2'd3; tick(1);
    read_time("R3 no link x1", 64'd111000);
    link_speed = 2'd0; tick(2);
    read_time("R3 fast x1", 64'd113000);
  endtask

  task automatic t_trim();
    set_time(64'd0);
    trim_ld = 1'b1; trim_val = 24'd777; inc_wr = 1'b1; inc_wdata = 24'd555;
    step();
    trim_ld = 1'b0; inc_wr = 1'b0;
    tick(1);
    read_time("R5 trim beats write", 64'd777);
    trim_ld = 1'b1; trim_val = 24'hFFFFFF;
    step();
    trim_ld = 1'b0;
    link_speed = 2'd2; tick(1);
    link_speed = 2'd0;
    read_time("R5 trim max x100", 64'd777 + 64'd100 * 64'hFFFFFF);
  endtask

  task automatic t_coherent();
    logic [31:0] lo, hi;
    write_inc(24'h100);
    set_time(64'h0000_0005_FFFF_FFF0);
    rd(1'b0, lo);
    chk("R7 low word", 64'(lo), 64'hFFFF_FFF0);
    tick(1);
    rd(1'b1, hi);
    chk("R7 shadow pre-carry", 64'(hi), 64'd5);
    read_time("R7 after carry", 64'h0000_0006_0000_00F0);
  endtask

  task automatic t_wrap();
    set_time(64'hFFFF_FFFF_FFFF_FF80);
    tick(1);
    read_time("R9 wrap", 64'h80);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_set();
    t_inc_write();
    t_speed();
    t_trim();
    t_coherent();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule